// File: doc/BRIEF.md
# ATA Programmed-I/O Cycle Engine

This block turns single-cycle register accesses from a CPU-side port into timed programmed-I/O cycles on a parallel ATA device bus. A write to a taskfile, data or control index is posted: the block captures the address and data, answers at once, and plays out the bus write cycle by itself. A read is split into two steps. The first access only launches the bus read cycle. The value the device returns is captured at the end of the strobe and held in a read-data output, which software fetches once the busy flag has cleared.

Each bus cycle has three phases: address setup, strobe active and end-of-cycle recovery. Their lengths, in controller clocks, come from a packed timing word. An optional device-ready input can stretch the strobe. The 16-bit data register can have its two bytes swapped. All other registers carry 8-bit values.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset, `host_busy` is 0, both strobes (`ata_rd_n`, `ata_wr_n`) are 1, `ata_cs_n` is 2'b11, `ata_doe` is 0 and `rd_data` is 0.
- R2: The timing word packs the setup count in bits [3:0], the strobe count in bits [11:4] and the recovery count in bits [19:12]. A count of zero means one cycle. The setup phase lasts T1 cycles, with the address and chip selects valid and both strobes high.
- R3: With device-ready sampling disabled, the active strobe stays low for exactly T2 cycles.
- R4: `host_busy` rises on the clock edge that accepts a `cpu_wr` or `cpu_rd` strobe. It then stays high for T1+T2+T3 cycles (plus any ready stretch) and falls as the recovery phase ends.
- R5: A `cpu_wr` or `cpu_rd` presented while `host_busy` is 1 is ignored. It starts no cycle, changes no bus output and does not lengthen the busy period.
- R6: A write drives `ata_wr_n` low during the strobe and drives `ata_doe`=1 for the whole cycle. For index 0 `ata_dout` carries the 16-bit word. For any other index it carries {8'h00, low byte}.
- R7: A read drives `ata_rd_n` low and captures `ata_din` on the last strobe cycle. `rd_data` holds the captured value after busy clears: the full word for index 0, {8'h00, `ata_din`[7:0]} for other indices. Writes leave `rd_data` unchanged.
- R8: For `cpu_addr` 0 to 7, a cycle drives `ata_addr`=`cpu_addr`[2:0] and `ata_cs_n`=2'b10. `cpu_addr`=8 selects the control block with `ata_addr`=6 and `ata_cs_n`=2'b01.
- R9: With `cfg_swap`=1, the two bytes of index-0 words are exchanged in both directions. The swap has no effect on 8-bit registers.
- R10: With `cfg_iordy_en`=1, each clock edge in the strobe phase that samples `ata_iordy`=0 holds the strobe count, so the strobe lasts T2 plus that many cycles. With `cfg_iordy_en`=0, `ata_iordy` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Single-cycle request to post a bus write |
| cpu_rd | input | 1 | Single-cycle request to launch a bus read |
| cpu_addr | input | 4 | Register index: 0-7 taskfile, 8 control block |
| cpu_wdata | input | 16 | Write data |
| cfg_timing | input | 20 | Packed setup, strobe and recovery counts |
| cfg_iordy_en | input | 1 | Enable device-ready strobe stretching |
| cfg_swap | input | 1 | Swap bytes of data-register words |
| host_busy | output | 1 | High while a bus cycle is in progress |
| rd_data | output | 16 | Value captured by the last bus read |
| ata_addr | output | 3 | Device register address |
| ata_cs_n | output | 2 | Chip selects, active low (bit0 taskfile, bit1 control) |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Bus write data |
| ata_doe | output | 1 | Bus data output enable |
| ata_din | input | 16 | Bus read data |
| ata_iordy | input | 1 | Device ready |

## Verification
The bench sweeps every setup count 0 to 3 against several strobe and recovery counts, including zero. It measures the busy, setup and strobe lengths of each cycle, so a design that treats a zero count as zero cycles, or as 16 or 256, or that counts one cycle too many, gives a different length. It pokes the port during a busy cycle. A design that accepts that access would show a second strobe, a changed address or a longer busy period. It also stretches the strobe with the ready input both enabled and disabled, which catches a gate that is inverted or ignored. Byte swap and read capture are checked on the data register and on 8-bit registers, which catches a swap or a zero-extension applied to the wrong width.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } pio_phase_e;

  localparam int unsigned CTL_BLOCK_REG = 6;
endpackage

// File: rtl/pio_phase_ctrl.sv
module pio_phase_ctrl
  import ata_pio_pkg::*;
#(
  parameter int T1_W = 4,
  parameter int T2_W = 8,
  parameter int T3_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [T1_W-1:0] setup_raw,
  input  logic [T2_W-1:0] strobe_raw,
  input  logic [T3_W-1:0] recov_raw,
  input  logic            iordy_en,
  input  logic            iordy,
  output pio_phase_e      phase,
  output logic            busy,
  output logic            capture
);
  localparam int W12   = (T1_W > T2_W) ? T1_W : T2_W;
  localparam int CNT_W = (W12 > T3_W) ? W12 : T3_W;

  pio_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len1_q, len2_q, len3_q;
  logic [CNT_W-1:0] eff1, eff2, eff3, len_cur;
  logic             last, hold, load_len;

  always_comb begin
    eff1 = (setup_raw  == '0) ? CNT_W'(1) : CNT_W'(setup_raw);
    eff2 = (strobe_raw == '0) ? CNT_W'(1) : CNT_W'(strobe_raw);
    eff3 = (recov_raw  == '0) ? CNT_W'(1) : CNT_W'(recov_raw);
    case (phase_q)
      PH_SETUP:   len_cur = len1_q;
      PH_STROBE:  len_cur = len2_q;
      PH_RECOVER: len_cur = len3_q;
      default:    len_cur = CNT_W'(1);
    endcase
    last     = (cnt_q == len_cur - CNT_W'(1));
    hold     = (phase_q == PH_STROBE) && iordy_en && !iordy;
    load_len = start && (phase_q == PH_IDLE);
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = '0;
        end
      end
      PH_SETUP: begin
        if (last) begin
          phase_d = PH_STROBE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (!hold) begin
          if (last) begin
            phase_d = PH_RECOVER;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      PH_RECOVER: begin
        if (last) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len1_q <= CNT_W'(1);
      len2_q <= CNT_W'(1);
      len3_q <= CNT_W'(1);
    end else if (load_len) begin
      len1_q <= eff1;
      len2_q <= eff2;
      len3_q <= eff3;
    end
  end

  assign phase   = phase_q;
  assign busy    = (phase_q != PH_IDLE);
  assign capture = (phase_q == PH_STROBE) && last && !hold;

  // R10
  iordy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE && iordy_en && !iordy) |=> (phase_q == PH_STROBE && $stable(cnt_q)));
  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RECOVER && last) |=> (phase_q == PH_IDLE));
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (cnt_q < len_cur));
endmodule

// File: rtl/pio_data_path.sv
module pio_data_path
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  parameter int BUS_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              acc_wr,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              swap_en,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_din,
  output logic              is_wr,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [1:0]        bus_cs_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HALF = DATA_W / 2;

  logic              wr_q, wide_q;
  logic [BUS_AW-1:0] addr_q, addr_d;
  logic [1:0]        cs_q, cs_d;
  logic [DATA_W-1:0] dout_q, dout_d, rd_q, rd_d;
  logic              swap_q;
  logic              is_ctl, wide_d;
  logic [DATA_W-1:0] wswap, rswap;

  always_comb begin
    is_ctl = acc_idx[IDX_W-1];
    wide_d = (acc_idx == '0);
    addr_d = is_ctl ? BUS_AW'(CTL_BLOCK_REG) : acc_idx[BUS_AW-1:0];
    cs_d   = is_ctl ? 2'b01 : 2'b10;
    wswap  = {acc_wdata[HALF-1:0], acc_wdata[DATA_W-1:HALF]};
    if (wide_d) dout_d = swap_en ? wswap : acc_wdata;
    else        dout_d = {{HALF{1'b0}}, acc_wdata[HALF-1:0]};
    rswap  = {bus_din[HALF-1:0], bus_din[DATA_W-1:HALF]};
    if (wide_q) rd_d = swap_q ? rswap : bus_din;
    else        rd_d = {{HALF{1'b0}}, bus_din[HALF-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      addr_q <= '0;
      cs_q   <= 2'b11;
      dout_q <= '0;
      swap_q <= 1'b0;
    end else if (accept) begin
      wr_q   <= acc_wr;
      wide_q <= wide_d;
      addr_q <= addr_d;
      cs_q   <= cs_d;
      dout_q <= dout_d;
      swap_q <= swap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_q <= '0;
    else if (capture && !wr_q) rd_q <= rd_d;
  end

  assign is_wr    = wr_q;
  assign bus_addr = addr_q;
  assign bus_cs_n = cs_q;
  assign bus_dout = dout_q;
  assign rd_data  = rd_q;

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && !wr_q) |=> $stable(rd_data));
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  parameter int BUS_AW = 3,
  parameter int T1_W   = 4,
  parameter int T2_W   = 8,
  parameter int T3_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_wr,
  input  logic                      cpu_rd,
  input  logic [IDX_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  input  logic [T1_W+T2_W+T3_W-1:0] cfg_timing,
  input  logic                      cfg_iordy_en,
  input  logic                      cfg_swap,
  output logic                      host_busy,
  output logic [DATA_W-1:0]         rd_data,
  output logic [BUS_AW-1:0]         ata_addr,
  output logic [1:0]                ata_cs_n,
  output logic                      ata_rd_n,
  output logic                      ata_wr_n,
  output logic [DATA_W-1:0]         ata_dout,
  output logic                      ata_doe,
  input  logic [DATA_W-1:0]         ata_din,
  input  logic                      ata_iordy
);
  localparam int T2_LO = T1_W;
  localparam int T3_LO = T1_W + T2_W;

  pio_phase_e        phase;
  logic              busy, capture, accept, is_wr;
  logic [1:0]        cs_q;
  logic              in_strobe;

  assign accept = (cpu_wr || cpu_rd) && !busy;

  pio_phase_ctrl #(.T1_W(T1_W), .T2_W(T2_W), .T3_W(T3_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .setup_raw  (cfg_timing[T1_W-1:0]),
    .strobe_raw (cfg_timing[T2_LO +: T2_W]),
    .recov_raw  (cfg_timing[T3_LO +: T3_W]),
    .iordy_en   (cfg_iordy_en),
    .iordy      (ata_iordy),
    .phase      (phase),
    .busy       (busy),
    .capture    (capture)
  );

  pio_data_path #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BUS_AW(BUS_AW)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .acc_wr    (cpu_wr),
    .acc_idx   (cpu_addr),
    .acc_wdata (cpu_wdata),
    .swap_en   (cfg_swap),
    .capture   (capture),
    .bus_din   (ata_din),
    .is_wr     (is_wr),
    .bus_addr  (ata_addr),
    .bus_cs_n  (cs_q),
    .bus_dout  (ata_dout),
    .rd_data   (rd_data)
  );

  assign in_strobe = (phase == PH_STROBE);
  assign ata_wr_n  = !(in_strobe && is_wr);
  assign ata_rd_n  = !(in_strobe && !is_wr);
  assign ata_cs_n  = busy ? cs_q : 2'b11;
  assign ata_doe   = busy && is_wr;
  assign host_busy = busy;

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_busy) |-> $past(cpu_wr || cpu_rd));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));
  // R5
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy && (cpu_wr || cpu_rd)) |=> (!host_busy || $stable({ata_addr, ata_cs_n, ata_dout})));
endmodule

// File: tb/ata_pio_engine_tb_top.sv
module ata_pio_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr, cpu_rd;
  logic [3:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic [19:0] cfg_timing;
  logic        cfg_iordy_en, cfg_swap;
  logic        host_busy;
  logic [15:0] rd_data;
  logic [2:0]  ata_addr;
  logic [1:0]  ata_cs_n;
  logic        ata_rd_n, ata_wr_n;
  logic [15:0] ata_dout;
  logic        ata_doe;
  logic [15:0] ata_din;
  logic        ata_iordy;

  int checks = 0;
  int errors = 0;
  logic [15:0] last_rd = 16'h0;
  bit done = 0;

  always #10 clk = ~clk;

  ata_pio_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cfg_timing(cfg_timing),
    .cfg_iordy_en(cfg_iordy_en), .cfg_swap(cfg_swap), .host_busy(host_busy),
    .rd_data(rd_data), .ata_addr(ata_addr), .ata_cs_n(ata_cs_n),
    .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_dout(ata_dout),
    .ata_doe(ata_doe), .ata_din(ata_din), .ata_iordy(ata_iordy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic access(input bit wr, input int idx, input logic [15:0] wd,
                        input int t1, input int t2, input int t3,
                        input int low_n, input bit poke);
    int busy_n = 0, setup_n = 0, strobe_n = 0, low_left = low_n, guard = 0;
    int exp_t2;
    logic [15:0] exp_dout, exp_rd;
    logic [2:0]  exp_addr;
    logic [1:0]  exp_cs;
    bit addr_ok = 1, dout_ok = 1, other_ok = 1;
    exp_t2 = eff(t2) + (cfg_iordy_en ? low_n : 0);
    exp_addr = (idx == 8) ? 3'd6 : 3'(idx);
    exp_cs   = (idx == 8) ? 2'b01 : 2'b10;
    if (idx == 0) exp_dout = cfg_swap ? {wd[7:0], wd[15:8]} : wd;
    else          exp_dout = {8'h00, wd[7:0]};
    if (idx == 0) exp_rd = cfg_swap ? {ata_din[7:0], ata_din[15:8]} : ata_din;
    else          exp_rd = {8'h00, ata_din[7:0]};
    @(negedge clk);
    cfg_timing = {8'(t3), 8'(t2), 4'(t1)};
    cpu_addr = 4'(idx);
    cpu_wdata = wd;
    cpu_wr = wr;
    cpu_rd = !wr;
    @(negedge clk);
    cpu_wr = 0;
    cpu_rd = 0;
    chk(host_busy == 1'b1, "R4 busy after accept", {31'b0, host_busy}, 1);
    while (host_busy && guard < 2000) begin
      bit strb;
      guard++;
      busy_n++;
      strb = wr ? !ata_wr_n : !ata_rd_n;
      if (wr ? !ata_rd_n : !ata_wr_n) other_ok = 0;
      if (ata_addr != exp_addr || ata_cs_n != exp_cs) addr_ok = 0;
      if (wr && (ata_dout != exp_dout || !ata_doe)) dout_ok = 0;
      if (strb) strobe_n++;
      else if (strobe_n == 0) setup_n++;
      if (strb && low_left > 0) begin
        ata_iordy = 0;
        low_left--;
      end else ata_iordy = 1;
      if (poke && busy_n == 2) begin
        cpu_wr = 1;
        cpu_addr = 4'd5;
        cpu_wdata = 16'hA5C3;
      end else cpu_wr = 0;
      @(negedge clk);
    end
    cpu_wr = 0;
    ata_iordy = 1;
    chk(busy_n == eff(t1) + exp_t2 + eff(t3), "R4 busy length", busy_n, eff(t1) + exp_t2 + eff(t3));
    chk(setup_n == eff(t1), "R2 setup length", setup_n, eff(t1));
    chk(strobe_n == exp_t2, cfg_iordy_en ? "R10 stretched strobe" : "R3 strobe width", strobe_n, exp_t2);
    chk(addr_ok, "R8 address/select", {27'b0, ata_addr, ata_cs_n}, {27'b0, exp_addr, exp_cs});
    chk(other_ok, "R6 opposite strobe idle", 0, 0);
    if (wr) begin
      chk(dout_ok, cfg_swap ? "R9 write swap" : "R6 write data", ata_dout, exp_dout);
      chk(rd_data == last_rd, "R7 rd_data kept on write", rd_data, last_rd);
    end else begin
      chk(rd_data == exp_rd, cfg_swap ? "R9 read swap" : "R7 read capture", rd_data, exp_rd);
      last_rd = exp_rd;
    end
    for (int k = 0; k < 3; k++) begin
      chk(!host_busy && ata_wr_n && ata_rd_n, "R5 no cycle from ignored access",
          {29'b0, host_busy, ata_wr_n, ata_rd_n}, 3'b011);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 0; cpu_wr = 0; cpu_rd = 0; cpu_addr = 0; cpu_wdata = 0;
    cfg_timing = 0; cfg_iordy_en = 0; cfg_swap = 0; ata_din = 16'h0; ata_iordy = 1;
    repeat (3) @(negedge clk);
    chk(!host_busy && ata_rd_n && ata_wr_n && ata_cs_n == 2'b11 && !ata_doe && rd_data == 0,
        "R1 reset state", {host_busy, ata_rd_n, ata_wr_n, ata_cs_n, ata_doe, rd_data},
        {1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 16'h0});
    rst_n = 1;
    @(negedge clk);
    // R2 R3 R4 R6 R7 R8: sweep of phase counts, alternating write and read
    for (int a = 0; a < 4; a++)
      for (int bi = 0; bi < 4; bi++)
        for (int c = 0; c < 3; c++) begin
          int t2v, t3v, idx;
          t2v = (bi == 3) ? 5 : bi;
          t3v = (c == 2) ? 3 : c;
          idx = (a * 3 + bi + c) % 9;
          ata_din = 16'h1000 * 16'(a) + 16'h0100 * 16'(bi) + 16'h0031 + 16'(c);
          access(1, idx, 16'hB000 + 16'(idx * 17), a, t2v, t3v, 0, 0);
          access(0, idx, 16'h0, a, t2v, t3v, 0, 0);
        end
    // R9: swap on data register and on an 8-bit register
    cfg_swap = 1;
    ata_din = 16'h12F0;
    access(1, 0, 16'hBEEF, 1, 2, 1, 0, 0);
    access(0, 0, 16'h0, 1, 2, 1, 0, 0);
    access(1, 3, 16'hBEEF, 1, 2, 1, 0, 0);
    access(0, 3, 16'h0, 1, 2, 1, 0, 0);
    cfg_swap = 0;
    // R10: ready stretch enabled, then ignored when disabled
    cfg_iordy_en = 1;
    access(0, 7, 16'h0, 2, 1, 1, 3, 0);
    access(1, 0, 16'h4321, 1, 4, 2, 2, 0);
    cfg_iordy_en = 0;
    access(0, 7, 16'h0, 2, 3, 1, 4, 0);
    // R5: access presented while busy is ignored
    ata_din = 16'h7E11;
    access(1, 2, 16'h005A, 2, 4, 2, 0, 1);
    access(0, 1, 16'h0, 2, 4, 2, 0, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule